// File: doc/BRIEF.md
# Multi-Mode Infrared Array Readout Sequencer

This block decides, for one exposure of an infrared detector array, the order in which the array is reset and read. It does not generate pixel clock waveforms. Each step goes out as a one-cycle command to a downstream frame clocker, which performs the reset or the full-frame read. The clocker answers with a one-cycle acknowledge when that frame is finished. Only then does the sequencer take its next step.

Three sampling schemes are selected at start time:
- single-sampled: one reset, then a group of non-destructive sample reads;
- double-sampled: one reset, a group of pedestal reads, then a group of sample reads;
- ramp: one reset, then a run of sample reads up the integration ramp.

The read group size, the ramp length, the coadd count and the integration time in milliseconds are captured when a start strobe is accepted. Out-of-range values are clamped at that point. The whole pattern repeats once per coadd, and a done command marks the end of the exposure. A millisecond timer built from a clock divider times the integration gap.

While idle, the block resets the array periodically in the background. An abort strobe ends an exposure quickly:
- if it arrives during an integration gap, the exposure stops at once;
- if it arrives while a frame is being clocked, that frame is allowed to finish.

In both cases the block then goes idle and shows an aborted flag.

Top module: `readout_sequencer`

## Requirements
- R1: With mode 0 (single-sampled), each coadd issues one reset command followed by `ndr` sample-read commands.
- R2: With mode 1 (double-sampled), each coadd issues one reset, then `ndr` pedestal-read commands, then `ndr` sample-read commands.
- R3: With mode 2 (ramp), each coadd issues one reset followed by `ramp` sample-read commands, with no integration gap; `ndr` has no effect in this mode.
- R4: The pattern repeats `coadd` times, then one `cmd_done_o` pulse is issued in the cycle after the last acknowledge, together with `busy_o` falling.
- R5: Timing of commands.
  - The first command follows the accepted start by one cycle.
  - In modes 0 and 1, the first sample read of a coadd is issued itime×CLK_PER_MS+2 cycles after the cycle in which the acknowledge of the reset (mode 0) or of the last pedestal (mode 1) is high.
  - Every other command is issued the cycle after the acknowledge of its predecessor.
- R6: At most one command output is high in any cycle, and a new reset or read is issued only after the previous one has been acknowledged.
- R7: `ndr` is clamped to the range 1..128 when start is accepted (0 acts as 1, 200 acts as 128).
- R8: `ramp` is clamped to the range 3..10 (1 acts as 3, 15 acts as 10), and mode 3 behaves as mode 2.
- R9: `coadd` is clamped to the range 1..1000 (0 acts as 1, 1023 acts as 1000), and an integration time of 0 ms acts as 1 ms.
- R10: Background resets while idle.
  - While idle, a background reset command is issued BG_PERIOD cycles after the cycle of the last done command.
  - Each later background reset follows the previous one's acknowledge by BG_PERIOD+1 cycles.
  - `busy_o` stays low and no read or done command is issued during this time.
- R11: An abort during the integration gap returns the block to idle in the next cycle with `aborted_o` high, and no further read or done command follows.
- R12: An abort while a reset or read is outstanding waits for that acknowledge, then goes idle with `aborted_o` high; no later command of the exposure is issued.
- R13: During reset, all command outputs, `busy_o` and `aborted_o` are low.
- R14: An abort while idle has no effect: `aborted_o` stays low and the background reset schedule is not disturbed. An accepted start clears `aborted_o` and raises `busy_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted while not busy |
| abort_i | input | 1 | Abort strobe |
| mode_i | input | 2 | 0 single-sampled, 1 double-sampled, 2 or 3 ramp |
| ndr_i | input | NDR_W (8) | Reads per pedestal or sample group |
| ramp_i | input | RAMP_W (4) | Ramp sample count |
| coadd_i | input | COADD_W (10) | Number of coadds |
| itime_i | input | ITIME_W (21) | Integration time in ms |
| frame_ack_i | input | 1 | One-cycle acknowledge from the frame clocker |
| cmd_reset_o | output | 1 | Reset command pulse (exposure or background) |
| cmd_ped_o | output | 1 | Pedestal read command pulse |
| cmd_smp_o | output | 1 | Sample read command pulse |
| cmd_done_o | output | 1 | Exposure complete pulse |
| busy_o | output | 1 | Exposure in progress |
| aborted_o | output | 1 | Last exposure ended by abort |

## Verification
The bench sweeps the three modes over small read counts, ramp lengths, coadd counts and integration times. It logs every command together with the time of its acknowledge, so that both the order and the cycle spacing are compared against arithmetic expectations.

The corner cases are targeted individually:
- Off-by-one read loops: a design with this fault shows one read too many or too few per group.
- Coadd wrap: a fault here repeats or drops a reset between coadds.
- Gap timer: a fault here places the first sample one divider period early or late.
- Clamp values at both ends of each range: a fault here reads 0 or 200 frames literally.

Aborts are applied in the gap, during an outstanding read, and while idle. A faulty design would keep issuing reads after an abort, would drop the pending acknowledge, or would raise the flag spuriously. The spacing of background resets exposes a counter that restarts on an ignored abort or that fires during an exposure.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_BG   = 3'd1,
        ST_RST  = 3'd2,
        ST_PED  = 3'd3,
        ST_GAP  = 3'd4,
        ST_SMP  = 3'd5
    } seq_state_e;

    localparam logic [1:0] MODE_SINGLE = 2'd0;
    localparam logic [1:0] MODE_DOUBLE = 2'd1;
    localparam logic [1:0] MODE_RAMP   = 2'd2;

endpackage

// File: rtl/seq_cfg_clamp.sv
module seq_cfg_clamp #(
    parameter int NDR_MAX   = 128,
    parameter int RAMP_MIN  = 3,
    parameter int RAMP_MAX  = 10,
    parameter int COADD_MAX = 1000,
    parameter int ITIME_MAX = 1800000,
    parameter int NDR_W     = 8,
    parameter int RAMP_W    = 4,
    parameter int COADD_W   = 10,
    parameter int ITIME_W   = 21
) (
    input  logic [1:0]         mode_i,
    input  logic [NDR_W-1:0]   ndr_i,
    input  logic [RAMP_W-1:0]  ramp_i,
    input  logic [COADD_W-1:0] coadd_i,
    input  logic [ITIME_W-1:0] itime_i,
    output logic [1:0]         mode_o,
    output logic [NDR_W-1:0]   ndr_o,
    output logic [RAMP_W-1:0]  ramp_o,
    output logic [COADD_W-1:0] coadd_o,
    output logic [ITIME_W-1:0] itime_o
);
    import seq_pkg::*;

    always_comb begin
        mode_o = (mode_i == 2'd3) ? MODE_RAMP : mode_i;

        if (ndr_i == '0)                     ndr_o = NDR_W'(1);
        else if (ndr_i > NDR_W'(NDR_MAX))    ndr_o = NDR_W'(NDR_MAX);
        else                                 ndr_o = ndr_i;

        if (ramp_i < RAMP_W'(RAMP_MIN))      ramp_o = RAMP_W'(RAMP_MIN);
        else if (ramp_i > RAMP_W'(RAMP_MAX)) ramp_o = RAMP_W'(RAMP_MAX);
        else                                 ramp_o = ramp_i;

        if (coadd_i == '0)                       coadd_o = COADD_W'(1);
        else if (coadd_i > COADD_W'(COADD_MAX))  coadd_o = COADD_W'(COADD_MAX);
        else                                     coadd_o = coadd_i;

        if (itime_i == '0)                       itime_o = ITIME_W'(1);
        else if (itime_i > ITIME_W'(ITIME_MAX))  itime_o = ITIME_W'(ITIME_MAX);
        else                                     itime_o = itime_i;
    end

endmodule

// File: rtl/seq_ms_timer.sv
module seq_ms_timer #(
    parameter int CLK_PER_MS = 100000,
    parameter int CNT_W      = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             expired_o
);
    localparam int DIV_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_MS - 1);

    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] ms;
        logic             exp;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d     = q;
        d.exp = 1'b0;
        if (!en_i) begin
            d.run = 1'b0;
        end
        if (load_i) begin
            d.run = 1'b1;
            d.div = '0;
            d.ms  = count_i;
        end else if (q.run && en_i) begin
            if (q.div == DIV_LAST) begin
                d.div = '0;
                d.ms  = q.ms - 1'b1;
                if (q.ms == CNT_W'(1)) begin
                    d.run = 1'b0;
                    d.exp = 1'b1;
                end
            end else begin
                d.div = q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expired_o = q.exp;

    AST_TIMER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        q.exp |=> !q.exp) else $error("timer expiry longer than one cycle"); // R5
    AST_TIMER_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.exp && !load_i) |-> !q.run) else $error("timer still running after expiry"); // R5

endmodule

// File: rtl/readout_sequencer.sv
module readout_sequencer #(
    parameter int CLK_PER_MS = 100000,
    parameter int BG_PERIOD  = 1000,
    parameter int NDR_MAX    = 128,
    parameter int RAMP_MIN   = 3,
    parameter int RAMP_MAX   = 10,
    parameter int COADD_MAX  = 1000,
    parameter int ITIME_MAX  = 1800000,
    localparam int NDR_W     = $clog2(NDR_MAX) + 1,
    localparam int RAMP_W    = $clog2(RAMP_MAX + 1),
    localparam int COADD_W   = $clog2(COADD_MAX + 1),
    localparam int ITIME_W   = $clog2(ITIME_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               abort_i,
    input  logic [1:0]         mode_i,
    input  logic [NDR_W-1:0]   ndr_i,
    input  logic [RAMP_W-1:0]  ramp_i,
    input  logic [COADD_W-1:0] coadd_i,
    input  logic [ITIME_W-1:0] itime_i,
    input  logic               frame_ack_i,
    output logic               cmd_reset_o,
    output logic               cmd_ped_o,
    output logic               cmd_smp_o,
    output logic               cmd_done_o,
    output logic               busy_o,
    output logic               aborted_o
);
    import seq_pkg::*;

    localparam int RD_W   = (NDR_W > RAMP_W) ? NDR_W : RAMP_W;
    localparam int IDLE_W = $clog2(BG_PERIOD + 1);
    localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(BG_PERIOD - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [1:0]         mode;
        logic [RD_W-1:0]    nreads;
        logic [COADD_W-1:0] coadds;
        logic [ITIME_W-1:0] itime;
        logic [RD_W-1:0]    rd_idx;
        logic [COADD_W-1:0] co_idx;
        logic               abort_pend;
        logic               aborted;
        logic [IDLE_W-1:0]  idle_cnt;
        logic               c_rst;
        logic               c_ped;
        logic               c_smp;
        logic               c_done;
    } seq_t;

    seq_t q, d;

    logic [1:0]         cl_mode;
    logic [NDR_W-1:0]   cl_ndr;
    logic [RAMP_W-1:0]  cl_ramp;
    logic [COADD_W-1:0] cl_coadd;
    logic [ITIME_W-1:0] cl_itime;
    logic               tmr_load, tmr_en, tmr_exp;
    logic               abort_now, last_rd, last_co;

    seq_cfg_clamp #(
        .NDR_MAX(NDR_MAX), .RAMP_MIN(RAMP_MIN), .RAMP_MAX(RAMP_MAX),
        .COADD_MAX(COADD_MAX), .ITIME_MAX(ITIME_MAX),
        .NDR_W(NDR_W), .RAMP_W(RAMP_W), .COADD_W(COADD_W), .ITIME_W(ITIME_W)
    ) u_clamp (
        .mode_i(mode_i), .ndr_i(ndr_i), .ramp_i(ramp_i),
        .coadd_i(coadd_i), .itime_i(itime_i),
        .mode_o(cl_mode), .ndr_o(cl_ndr), .ramp_o(cl_ramp),
        .coadd_o(cl_coadd), .itime_o(cl_itime)
    );

    seq_ms_timer #(
        .CLK_PER_MS(CLK_PER_MS), .CNT_W(ITIME_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .en_i(tmr_en),
        .count_i(q.itime), .expired_o(tmr_exp)
    );

    function automatic seq_t take_cfg(input seq_t s);
        seq_t r;
        r            = s;
        r.mode       = cl_mode;
        r.nreads     = (cl_mode == MODE_RAMP) ? RD_W'(cl_ramp) : RD_W'(cl_ndr);
        r.coadds     = cl_coadd;
        r.itime      = cl_itime;
        r.rd_idx     = '0;
        r.co_idx     = '0;
        r.abort_pend = 1'b0;
        r.aborted    = 1'b0;
        r.idle_cnt   = '0;
        r.st         = ST_RST;
        return r;
    endfunction

    function automatic seq_t end_abort(input seq_t s);
        seq_t r;
        r            = s;
        r.st         = ST_IDLE;
        r.aborted    = 1'b1;
        r.abort_pend = 1'b0;
        r.idle_cnt   = '0;
        return r;
    endfunction

    always_comb begin
        d        = q;
        d.c_rst  = 1'b0;
        d.c_ped  = 1'b0;
        d.c_smp  = 1'b0;
        d.c_done = 1'b0;
        abort_now = q.abort_pend | abort_i;
        last_rd   = (q.rd_idx == q.nreads - 1'b1);
        last_co   = (q.co_idx == q.coadds - 1'b1);
        if (q.st inside {ST_RST, ST_PED, ST_GAP, ST_SMP}) begin
            d.abort_pend = abort_now;
        end

        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d       = take_cfg(d);
                    d.c_rst = 1'b1;
                end else if (q.idle_cnt == IDLE_LAST) begin
                    d.st       = ST_BG;
                    d.c_rst    = 1'b1;
                    d.idle_cnt = '0;
                end else begin
                    d.idle_cnt = q.idle_cnt + 1'b1;
                end
            end
            ST_BG: begin
                if (start_i) begin
                    d       = take_cfg(d);
                    d.c_rst = frame_ack_i;
                end else if (frame_ack_i) begin
                    d.st = ST_IDLE;
                end
            end
            ST_RST: begin
                if (frame_ack_i) begin
                    if (abort_now) begin
                        d = end_abort(d);
                    end else if (q.mode == MODE_SINGLE) begin
                        d.st = ST_GAP;
                    end else if (q.mode == MODE_DOUBLE) begin
                        d.st     = ST_PED;
                        d.c_ped  = 1'b1;
                        d.rd_idx = '0;
                    end else begin
                        d.st     = ST_SMP;
                        d.c_smp  = 1'b1;
                        d.rd_idx = '0;
                    end
                end
            end
            ST_PED: begin
                if (frame_ack_i) begin
                    if (abort_now) begin
                        d = end_abort(d);
                    end else if (last_rd) begin
                        d.st     = ST_GAP;
                        d.rd_idx = '0;
                    end else begin
                        d.rd_idx = q.rd_idx + 1'b1;
                        d.c_ped  = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (abort_now) begin
                    d = end_abort(d);
                end else if (tmr_exp) begin
                    d.st     = ST_SMP;
                    d.c_smp  = 1'b1;
                    d.rd_idx = '0;
                end
            end
            ST_SMP: begin
                if (frame_ack_i) begin
                    if (abort_now) begin
                        d = end_abort(d);
                    end else if (!last_rd) begin
                        d.rd_idx = q.rd_idx + 1'b1;
                        d.c_smp  = 1'b1;
                    end else if (last_co) begin
                        d.st     = ST_IDLE;
                        d.c_done = 1'b1;
                    end else begin
                        d.co_idx = q.co_idx + 1'b1;
                        d.st     = ST_RST;
                        d.c_rst  = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        tmr_en   = (d.st == ST_GAP);
        tmr_load = (d.st == ST_GAP) && (q.st != ST_GAP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_reset_o = q.c_rst;
    assign cmd_ped_o   = q.c_ped;
    assign cmd_smp_o   = q.c_smp;
    assign cmd_done_o  = q.c_done;
    assign busy_o      = (q.st != ST_IDLE) && (q.st != ST_BG);
    assign aborted_o   = q.aborted;

    AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_reset_o, cmd_ped_o, cmd_smp_o, cmd_done_o})) else $error("two commands at once"); // R6
    AST_NO_CMD_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st inside {ST_RST, ST_PED, ST_SMP, ST_BG} && !frame_ack_i && !start_i) |=> !(cmd_ped_o || cmd_smp_o || cmd_done_o)) else $error("command issued without acknowledge"); // R6
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done_o |-> (!busy_o && $past(busy_o))) else $error("done without end of exposure"); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(cmd_ped_o || cmd_smp_o)) else $error("read command while idle"); // R10
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        aborted_o |-> !(busy_o || cmd_ped_o || cmd_smp_o || cmd_done_o)) else $error("activity after abort"); // R11
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !aborted_o)) else $error("start not taken"); // R14
    AST_NDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && q.mode != MODE_RAMP) |-> (q.nreads >= RD_W'(1) && q.nreads <= RD_W'(NDR_MAX))) else $error("read count out of range"); // R7
    AST_RAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && q.mode == MODE_RAMP) |-> (q.nreads >= RD_W'(RAMP_MIN) && q.nreads <= RD_W'(RAMP_MAX))) else $error("ramp count out of range"); // R8
    AST_COADD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (q.coadds >= COADD_W'(1) && q.coadds <= COADD_W'(COADD_MAX) && q.itime != '0)) else $error("coadd or time out of range"); // R9

endmodule

// File: tb/readout_sequencer_test.sv
module readout_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int CPM        = 3;
    localparam int BGP        = 40;
    localparam int LOGN       = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        abort = 1'b0;
    logic [1:0]  mode = '0;
    logic [7:0]  ndr = '0;
    logic [3:0]  ramp = '0;
    logic [9:0]  coadd = '0;
    logic [20:0] itime = '0;
    logic        ack = 1'b0;
    logic        c_rst, c_ped, c_smp, c_done, busy, aborted;

    readout_sequencer #(.CLK_PER_MS(CPM), .BG_PERIOD(BGP)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
        .mode_i(mode), .ndr_i(ndr), .ramp_i(ramp), .coadd_i(coadd),
        .itime_i(itime), .frame_ack_i(ack),
        .cmd_reset_o(c_rst), .cmd_ped_o(c_ped), .cmd_smp_o(c_smp),
        .cmd_done_o(c_done), .busy_o(busy), .aborted_o(aborted)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int log_ty [LOGN];
    int log_st [LOGN];
    int ackst  [LOGN];
    int n = 0;
    int done_cnt = 0;
    int done_st = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // frame clocker model: acknowledge one negedge after each reset/read command
    initial begin
        bit apend;
        apend = 1'b0;
        forever begin
            @(negedge clk);
            ack = 1'b0;
            if (apend) begin
                apend = 1'b0;
                ack = 1'b1;
                ackst[n-1] = cyc;
            end
            if (c_rst || c_ped || c_smp) begin
                log_ty[n] = c_rst ? 1 : (c_ped ? 2 : 3);
                log_st[n] = cyc;
                n = n + 1;
                apend = 1'b1;
            end
            if (c_done) begin
                done_cnt = done_cnt + 1;
                done_st = cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // expected-sequence walker
    int ei, e_n0, e_start, ebad, eb_act, eb_exp;

    task automatic exp_cmd(input int ty, input int dly);
        int rt, act_ty, act_d;
        rt = (ei == e_n0) ? e_start : ackst[ei-1];
        act_ty = (ei < n) ? log_ty[ei] : -1;
        act_d  = (ei < n) ? (log_st[ei] - rt) : -1;
        if (act_ty != ty || act_d != dly) begin
            if (ebad == 0) begin
                eb_act = act_ty * 100000 + act_d;
                eb_exp = ty * 100000 + dly;
            end
            ebad++;
        end
        ei++;
    endtask

    task automatic run_exp(input int m, input int nd, input int rp, input int co,
                           input int it, input string tag);
        int em, en, er, ec, etm, rd, g, d0;
        em  = (m == 3) ? 2 : m;
        en  = (nd < 1) ? 1 : ((nd > 128) ? 128 : nd);
        er  = (rp < 3) ? 3 : ((rp > 10) ? 10 : rp);
        ec  = (co < 1) ? 1 : ((co > 1000) ? 1000 : co);
        etm = (it < 1) ? 1 : it;
        rd  = (em == 2) ? er : en;
        g   = etm * CPM + 2;
        @(negedge clk);
        e_n0 = n;
        d0 = done_cnt;
        mode = 2'(m); ndr = 8'(nd); ramp = 4'(rp); coadd = 10'(co); itime = 21'(it);
        start = 1'b1;
        e_start = cyc;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && aborted == 1'b0, "R14 start raises busy, clears aborted",
            {busy, aborted}, 2);
        while (done_cnt == d0) @(negedge clk);
        @(negedge clk);
        ei = e_n0; ebad = 0; eb_act = 0; eb_exp = 0;
        for (int c = 0; c < ec; c++) begin
            exp_cmd(1, 1);
            if (em == 1) for (int r = 0; r < en; r++) exp_cmd(2, 1);
            for (int r = 0; r < rd; r++) exp_cmd(3, (r == 0 && em != 2) ? g : 1);
        end
        if (n != ei) begin
            if (ebad == 0) begin eb_act = n - e_n0; eb_exp = ei - e_n0; end
            ebad++;
        end
        chk(ebad == 0, $sformatf("%s/R5 sequence m=%0d ndr=%0d ramp=%0d co=%0d t=%0d (type*1e5+delay)",
            tag, m, nd, rp, co, it), eb_act, eb_exp);
        chk(done_cnt == d0 + 1 && done_st == ackst[n-1] + 1 && busy == 1'b0,
            "R4 single done pulse after last acknowledge", done_st - ackst[n-1], 1);
    endtask

    initial begin
        int n0, d0, cnt, bsy;
        bit ok;
        repeat (3) @(negedge clk);
        chk({c_rst, c_ped, c_smp, c_done, busy, aborted} == 6'b0, "R13 outputs low in reset",
            {c_rst, c_ped, c_smp, c_done, busy, aborted}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && aborted == 1'b0, "R13 idle after reset", {busy, aborted}, 0);

        for (int m = 0; m < 2; m++)
            for (int nd = 1; nd <= 3; nd++)
                for (int co = 1; co <= 2; co++)
                    for (int t = 1; t <= 2; t++)
                        run_exp(m, nd, 4, co, t, (m == 0) ? "R1" : "R2");
        for (int rp = 3; rp <= 5; rp++)
            for (int co = 1; co <= 2; co++)
                run_exp(2, 2 + co, rp, co, 1, "R3");
        run_exp(2, 1, 10, 1, 2, "R3");

        run_exp(0, 0,   4, 1, 1, "R7 ndr 0");
        run_exp(1, 0,   4, 2, 1, "R7 ndr 0 double");
        run_exp(0, 200, 4, 1, 1, "R7 ndr 200");
        run_exp(2, 2,   1, 1, 1, "R8 ramp 1");
        run_exp(2, 2,  15, 1, 1, "R8 ramp 15");
        run_exp(3, 2,   4, 2, 1, "R8 mode 3");
        run_exp(0, 1,   4, 0, 1, "R9 coadd 0");
        run_exp(1, 1,   4, 1, 0, "R9 itime 0");
        run_exp(0, 1,   4, 1023, 1, "R9 coadd 1023");

        // abort during the integration gap
        @(negedge clk);
        n0 = n; d0 = done_cnt;
        mode = 2'd1; ndr = 8'd2; coadd = 10'd3; itime = 21'd10; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (n < n0 + 3) @(negedge clk);
        repeat (5) @(negedge clk);
        abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        chk(busy == 1'b0 && aborted == 1'b1, "R11 abort in gap ends at once", {busy, aborted}, 1);
        repeat (25) @(negedge clk);
        chk(n == n0 + 3 && done_cnt == d0, "R11 no command after gap abort", n - n0, 3);

        run_exp(0, 2, 4, 1, 1, "R14 after abort");

        // abort while a read is outstanding
        @(negedge clk);
        n0 = n; d0 = done_cnt;
        mode = 2'd0; ndr = 8'd3; coadd = 10'd5; itime = 21'd1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (n < n0 + 2) @(negedge clk);
        abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && aborted == 1'b1, "R12 abort after outstanding read", {busy, aborted}, 1);
        chk(ackst[n0+1] > log_st[n0+1], "R12 outstanding read acknowledged", ackst[n0+1] - log_st[n0+1], 1);
        repeat (25) @(negedge clk);
        chk(n == n0 + 2 && done_cnt == d0, "R12 no command after read abort", n - n0, 2);

        run_exp(1, 1, 4, 1, 1, "R14 second start");

        // abort while idle: ignored
        abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        @(negedge clk);
        chk(aborted == 1'b0 && busy == 1'b0, "R14 idle abort ignored", {busy, aborted}, 0);

        // background resets
        n0 = n; bsy = 0;
        for (int k = 0; k < 220; k++) begin
            @(negedge clk);
            if (busy || c_ped || c_smp || c_done) bsy++;
        end
        chk(bsy == 0, "R10 idle stays quiet", bsy, 0);
        cnt = n - n0;
        chk(cnt >= 4, "R10 background reset count", cnt, 5);
        chk(cnt > 0 && log_ty[n0] == 1 && log_st[n0] - done_st == BGP,
            "R10/R14 first background reset spacing", log_st[n0] - done_st, BGP);
        ok = 1'b1;
        for (int k = n0 + 1; k < n; k++)
            if (log_ty[k] != 1 || log_st[k] - ackst[k-1] != BGP + 1) ok = 1'b0;
        chk(ok, "R10 background reset period", ok, 1);

        finished = 1'b1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
            summary();
        end
    end

endmodule